// File: doc/BRIEF.md
# Miscellaneous System Control Register Bank

This block holds a small set of system control and status registers reached over a plain memory-mapped register bus. Each register has its own select line. An access is one cycle wide and completes in the cycle it is presented. The bus has no valid/ready handshake and no back-pressure: the block always accepts a write, and read data is combinational from the stored state.

There are five byte-wide registers: configuration, diagnostic, modem control, auxiliary-1 and auxiliary-2.

- Auxiliary-1 carries a self-clearing floppy terminal-count strobe.
- Auxiliary-2 controls software power-down. It holds a read-only power-fail flag that a write can clear.

There is also a 16-bit LED register and a 32-bit system-control register. The system-control register requests a system reset and latches a reset-status byte.

A level power-fail input, gated by a configuration enable, latches the power-fail flag. That flag drives a level interrupt. The shutdown, reset-request and terminal-count outputs are registered one-cycle pulses.

Top module: `misc_sysctl_regs`

## Requirements
- R1: A synchronous reset clears configuration, auxiliary-1, auxiliary-2, modem control and all outputs. Diagnostic, LED and system-control status keep their values across that reset.
- R2: Configuration, diagnostic and modem control are plain 8-bit read/write registers. Read data appears on bits 7:0 and the upper bits read 0.
- R3: An access takes effect only when its offset is 0 and its size matches the register. The size code is 0 for byte, 1 for halfword and 2 for word. Byte registers need size 0, the LED register needs size 1 and system control needs size 2. Any other access is ignored and reads 0.
- R4: An auxiliary-1 write with data bit 1 set raises the terminal-count output for exactly the one cycle after the write. Bit 1 is always stored as 0 and the other seven bits are stored as written.
- R5: On every change of the power-fail input, the flag (auxiliary-2 bit 5) is set if the input is now high and configuration bit 3 holds 1; otherwise it is cleared. If this happens in the same cycle as an auxiliary-2 write, the power-fail rule decides the flag, using configuration as it stood before that cycle.
- R6: An auxiliary-2 write keeps only data bits 0 (power-off) and 1 (interrupt clear), then ORs in the current flag. If bit 1 is set, only bit 0 survives. Bits 1 to 4, 6 and 7 therefore always read 0.
- R7: An auxiliary-2 write that leaves bit 0 stored as 1 emits a one-cycle shutdown-request pulse in the cycle after the write.
- R8: The interrupt output is a registered level equal to (flag AND configuration bit 3). It is valid in the cycle after any configuration write, auxiliary-2 write or power-fail change.
- R9: A system-control write at offset 0 with data bit 0 set loads the status byte with 0x02 and emits a one-cycle reset-request pulse. A write with bit 0 clear changes nothing. A read returns the status byte.
- R10: The LED register stores and returns all 16 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 7 | One-hot register select: 0 cfg, 1 diag, 2 modem, 3 aux1, 4 aux2, 5 led, 6 sysctl |
| acc_off | input | 2 | Byte offset inside the selected register |
| acc_size | input | 2 | Access size code: 0 byte, 1 halfword, 2 word |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, zero when no qualified read |
| pwr_fail | input | 1 | Level power-fail indication |
| irq_o | output | 1 | Power-fail interrupt level |
| fd_tc_o | output | 1 | Floppy terminal-count pulse |
| shutdown_o | output | 1 | Shutdown request pulse |
| sys_reset_o | output | 1 | System reset request pulse |

## Verification
A corrupted power-fail flag or configuration enable shows on the interrupt pin one cycle after the event that should have moved it. It also shows at once when auxiliary-2 is read back. Wrong masking of auxiliary-1 or auxiliary-2 shows on the next read. Because the pulse outputs are registered, a missing, stuck or doubled strobe is visible in the cycle right after the write and in the cycle after that. Register state that a reset wrongly clears or wrongly keeps is only exposed by a read after that reset, so the bench reads back every retained register once reset is released.

// File: rtl/misc_sysctl_pkg.sv
package misc_sysctl_pkg;
  localparam int NUM_REGS = 7;
  localparam int SEL_CFG  = 0;
  localparam int SEL_DIAG = 1;
  localparam int SEL_MDM  = 2;
  localparam int SEL_AUX1 = 3;
  localparam int SEL_AUX2 = 4;
  localparam int SEL_LED  = 5;
  localparam int SEL_SYS  = 6;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  localparam int CFG_PFEN_BIT  = 3;
  localparam int AUX1_TC_BIT   = 1;
  localparam int AUX2_OFF_BIT  = 0;
  localparam int AUX2_CLR_BIT  = 1;
  localparam int AUX2_FLAG_BIT = 5;
  localparam int SYS_REQ_BIT   = 0;
  localparam logic [7:0] SYS_STAT_RESET = 8'h02;

  function automatic acc_size_e size_of_reg(input int idx);
    if (idx == SEL_LED) return SZ_HALF;
    if (idx == SEL_SYS) return SZ_WORD;
    return SZ_BYTE;
  endfunction
endpackage

// File: rtl/msr_decode.sv
module msr_decode
  import misc_sysctl_pkg::*;
#(
  parameter int NREG  = NUM_REGS,
  parameter int OFF_W = 2
) (
  input  logic             valid,
  input  logic             write,
  input  logic [NREG-1:0]  sel,
  input  logic [OFF_W-1:0] off,
  input  logic [1:0]       size,
  output logic [NREG-1:0]  wr_en,
  output logic [NREG-1:0]  rd_en
);
  logic base_ok;
  assign base_ok = valid && (off == '0);

  for (genvar g = 0; g < NREG; g++) begin : g_qual
    localparam acc_size_e NEED = size_of_reg(g);
    logic hit;
    assign hit      = base_ok && sel[g] && (size == NEED);
    assign wr_en[g] = hit && write;
    assign rd_en[g] = hit && !write;
  end
endmodule

// File: rtl/msr_power.sv
module msr_power
  import misc_sysctl_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pf_in,
  input  logic              cfg_en_cur,
  input  logic              cfg_wr,
  input  logic              cfg_en_new,
  input  logic              aux2_wr,
  input  logic [BYTE_W-1:0] aux2_wdata,
  output logic [BYTE_W-1:0] aux2_value,
  output logic              irq,
  output logic              shutdown
);
  logic flag_q, flag_n;
  logic off_q, off_n;
  logic pf_prev;
  logic pf_chg;
  logic en_next;

  assign pf_chg  = pf_in != pf_prev;
  assign en_next = cfg_wr ? cfg_en_new : cfg_en_cur;

  always_comb begin
    flag_n = flag_q;
    off_n  = off_q;
    if (aux2_wr) begin
      off_n = aux2_wdata[AUX2_OFF_BIT];
      if (aux2_wdata[AUX2_CLR_BIT]) flag_n = 1'b0;
    end
    if (pf_chg) flag_n = pf_in && cfg_en_cur;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q   <= 1'b0;
      off_q    <= 1'b0;
      pf_prev  <= pf_in;
      irq      <= 1'b0;
      shutdown <= 1'b0;
    end else begin
      flag_q   <= flag_n;
      off_q    <= off_n;
      pf_prev  <= pf_in;
      irq      <= flag_n && en_next;
      shutdown <= aux2_wr && off_n;
    end
  end

  always_comb begin
    aux2_value                = '0;
    aux2_value[AUX2_OFF_BIT]  = off_q;
    aux2_value[AUX2_FLAG_BIT] = flag_q;
  end
endmodule

// File: rtl/msr_readmux.sv
module msr_readmux
  import misc_sysctl_pkg::*;
#(
  parameter int NREG   = NUM_REGS,
  parameter int DATA_W = 32
) (
  input  logic [NREG-1:0]   rd_en,
  input  logic [DATA_W-1:0] vals [NREG],
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_en[i]) rdata = rdata | vals[i];
    end
  end
endmodule

// File: rtl/misc_sysctl_regs.sv
module misc_sysctl_regs
  import misc_sysctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int LED_W  = 16,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [NUM_REGS-1:0] acc_sel,
  input  logic [OFF_W-1:0]  acc_off,
  input  logic [1:0]        acc_size,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  input  logic              pwr_fail,
  output logic              irq_o,
  output logic              fd_tc_o,
  output logic              shutdown_o,
  output logic              sys_reset_o
);
  localparam int BPAD = DATA_W - BYTE_W;
  localparam int LPAD = DATA_W - LED_W;

  logic [NUM_REGS-1:0] wr_en, rd_en;
  logic [BYTE_W-1:0]   cfg_q, diag_q, mdm_q, aux1_q, sys_stat_q, aux2_val;
  logic [LED_W-1:0]    led_q;
  logic [BYTE_W-1:0]   wbyte;
  logic [DATA_W-1:0]   rvals [NUM_REGS];

  assign wbyte = acc_wdata[BYTE_W-1:0];

  msr_decode #(.NREG(NUM_REGS), .OFF_W(OFF_W)) u_dec (
    .valid (acc_valid),
    .write (acc_write),
    .sel   (acc_sel),
    .off   (acc_off),
    .size  (acc_size),
    .wr_en (wr_en),
    .rd_en (rd_en)
  );

  msr_power #(.BYTE_W(BYTE_W)) u_pwr (
    .clk        (clk),
    .rst        (rst),
    .pf_in      (pwr_fail),
    .cfg_en_cur (cfg_q[CFG_PFEN_BIT]),
    .cfg_wr     (wr_en[SEL_CFG]),
    .cfg_en_new (wbyte[CFG_PFEN_BIT]),
    .aux2_wr    (wr_en[SEL_AUX2]),
    .aux2_wdata (wbyte),
    .aux2_value (aux2_val),
    .irq        (irq_o),
    .shutdown   (shutdown_o)
  );

  // registers cleared by the block reset
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q       <= '0;
      mdm_q       <= '0;
      aux1_q      <= '0;
      fd_tc_o     <= 1'b0;
      sys_reset_o <= 1'b0;
    end else begin
      if (wr_en[SEL_CFG]) cfg_q <= wbyte;
      if (wr_en[SEL_MDM]) mdm_q <= wbyte;
      if (wr_en[SEL_AUX1]) begin
        aux1_q              <= wbyte;
        aux1_q[AUX1_TC_BIT] <= 1'b0;
      end
      fd_tc_o     <= wr_en[SEL_AUX1] && wbyte[AUX1_TC_BIT];
      sys_reset_o <= wr_en[SEL_SYS] && acc_wdata[SYS_REQ_BIT];
    end
  end

  // registers kept across the block reset
  always_ff @(posedge clk) begin
    if (wr_en[SEL_DIAG]) diag_q <= wbyte;
    if (wr_en[SEL_LED])  led_q  <= acc_wdata[LED_W-1:0];
    if (wr_en[SEL_SYS] && acc_wdata[SYS_REQ_BIT]) sys_stat_q <= SYS_STAT_RESET;
  end

  assign rvals[SEL_CFG]  = {{BPAD{1'b0}}, cfg_q};
  assign rvals[SEL_DIAG] = {{BPAD{1'b0}}, diag_q};
  assign rvals[SEL_MDM]  = {{BPAD{1'b0}}, mdm_q};
  assign rvals[SEL_AUX1] = {{BPAD{1'b0}}, aux1_q};
  assign rvals[SEL_AUX2] = {{BPAD{1'b0}}, aux2_val};
  assign rvals[SEL_LED]  = {{LPAD{1'b0}}, led_q};
  assign rvals[SEL_SYS]  = {{BPAD{1'b0}}, sys_stat_q};

  msr_readmux #(.NREG(NUM_REGS), .DATA_W(DATA_W)) u_rmux (
    .rd_en (rd_en),
    .vals  (rvals),
    .rdata (acc_rdata)
  );
endmodule

// File: rtl/misc_sysctl_checker.sv
module misc_sysctl_checker
  import misc_sysctl_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                acc_valid,
  input logic                acc_write,
  input logic [NUM_REGS-1:0] acc_sel,
  input logic [1:0]          acc_off,
  input logic [1:0]          acc_size,
  input logic [31:0]         acc_wdata,
  input logic                irq_o,
  input logic                fd_tc_o,
  input logic                shutdown_o,
  input logic                sys_reset_o,
  input logic [7:0]          cfg_v,
  input logic [7:0]          aux1_v,
  input logic [7:0]          aux2_v,
  input logic [7:0]          stat_v
);
  logic byte_wr;
  assign byte_wr = acc_valid && acc_write && acc_off == 2'd0 && acc_size == 2'd0;

  assert_tc_cause_R4: assert property (@(posedge clk) disable iff (rst)
    fd_tc_o |-> $past(byte_wr && acc_sel[SEL_AUX1] && acc_wdata[AUX1_TC_BIT]));

  assert_tc_bit_clear_R4: assert property (@(posedge clk) disable iff (rst)
    aux1_v[AUX1_TC_BIT] == 1'b0);

  assert_aux2_mask_R6: assert property (@(posedge clk) disable iff (rst)
    (aux2_v & 8'hDE) == 8'h00);

  assert_shutdown_cause_R7: assert property (@(posedge clk) disable iff (rst)
    shutdown_o |-> $past(byte_wr && acc_sel[SEL_AUX2] && acc_wdata[AUX2_OFF_BIT])
                   && aux2_v[AUX2_OFF_BIT]);

  assert_irq_level_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o == (aux2_v[AUX2_FLAG_BIT] && cfg_v[CFG_PFEN_BIT]));

  assert_reset_status_R9: assert property (@(posedge clk) disable iff (rst)
    sys_reset_o |-> stat_v == SYS_STAT_RESET);
endmodule

bind misc_sysctl_regs misc_sysctl_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .acc_valid   (acc_valid),
  .acc_write   (acc_write),
  .acc_sel     (acc_sel),
  .acc_off     (acc_off),
  .acc_size    (acc_size),
  .acc_wdata   (acc_wdata),
  .irq_o       (irq_o),
  .fd_tc_o     (fd_tc_o),
  .shutdown_o  (shutdown_o),
  .sys_reset_o (sys_reset_o),
  .cfg_v       (cfg_q),
  .aux1_v      (aux1_q),
  .aux2_v      (aux2_val),
  .stat_v      (sys_stat_q)
);

// File: tb/test_misc_sysctl_regs.sv
module test_misc_sysctl_regs;
  localparam int CFG = 0, DIAG = 1, MDM = 2, AUX1 = 3, AUX2 = 4, LED = 5, SYS = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [6:0]  acc_sel = '0;
  logic [1:0]  acc_off = '0;
  logic [1:0]  acc_size = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        pwr_fail = 1'b0;
  logic        irq_o, fd_tc_o, shutdown_o, sys_reset_o;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  misc_sysctl_regs i_misc_sysctl_regs (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_sel(acc_sel), .acc_off(acc_off), .acc_size(acc_size),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .pwr_fail(pwr_fail),
    .irq_o(irq_o), .fd_tc_o(fd_tc_o), .shutdown_o(shutdown_o),
    .sys_reset_o(sys_reset_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [1:0] off, input logic [1:0] sz,
                    input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_sel = 7'(1 << idx);
    acc_off = off; acc_size = sz; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; acc_sel = '0; acc_wdata = '0;
  endtask

  task automatic rd(input int idx, input logic [1:0] off, input logic [1:0] sz,
                    output logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_sel = 7'(1 << idx);
    acc_off = off; acc_size = sz;
    #2 d = acc_rdata;
    acc_valid = 1'b0; acc_sel = '0;
  endtask

  task automatic expect_rd(input int idx, input logic [1:0] off, input logic [1:0] sz,
                           input logic [31:0] exp, input string req);
    logic [31:0] d;
    rd(idx, off, sz, d);
    check(d === exp, req, d, exp);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset_state();
    expect_rd(CFG, 0, 0, 32'h0, "R1 cfg after reset");
    expect_rd(AUX1, 0, 0, 32'h0, "R1 aux1 after reset");
    expect_rd(AUX2, 0, 0, 32'h0, "R1 aux2 after reset");
    expect_rd(MDM, 0, 0, 32'h0, "R1 modem after reset");
    check(!irq_o && !fd_tc_o && !shutdown_o && !sys_reset_o, "R1 outputs low",
          {irq_o, fd_tc_o, shutdown_o, sys_reset_o}, 0);
  endtask

  task automatic t_plain_rw();
    wr(CFG, 0, 0, 32'hFFFF_FFA5);
    wr(DIAG, 0, 0, 32'h0000_013C);
    wr(MDM, 0, 0, 32'h0000_005A);
    expect_rd(CFG, 0, 0, 32'hA5, "R2 cfg readback");
    expect_rd(DIAG, 0, 0, 32'h3C, "R2 diag readback");
    expect_rd(MDM, 0, 0, 32'h5A, "R2 modem readback");
    wr(CFG, 0, 0, 32'h0);
  endtask

  task automatic t_qualify();
    wr(LED, 0, 1, 32'h0001_BEEF);
    expect_rd(LED, 0, 1, 32'hBEEF, "R10 led 16-bit readback");
    wr(LED, 0, 0, 32'h0000_1111);
    expect_rd(LED, 0, 1, 32'hBEEF, "R3 led byte write ignored");
    wr(LED, 2, 1, 32'h0000_2222);
    expect_rd(LED, 0, 1, 32'hBEEF, "R3 led offset write ignored");
    expect_rd(LED, 2, 1, 32'h0, "R3 led offset read zero");
    expect_rd(LED, 0, 2, 32'h0, "R3 led word read zero");
    wr(MDM, 0, 1, 32'h77);
    expect_rd(MDM, 0, 0, 32'h5A, "R3 modem half write ignored");
    expect_rd(MDM, 1, 0, 32'h0, "R3 modem offset read zero");
    wr(SYS, 0, 0, 32'h1);
    check(!sys_reset_o, "R3 sysctl byte write ignored", sys_reset_o, 0);
  endtask

  task automatic t_aux1();
    wr(AUX1, 0, 0, 32'hFF);
    check(fd_tc_o, "R4 tc pulse high", fd_tc_o, 1);
    @(negedge clk);
    check(!fd_tc_o, "R4 tc pulse one cycle", fd_tc_o, 0);
    expect_rd(AUX1, 0, 0, 32'hFD, "R4 aux1 bit1 stored 0");
    wr(AUX1, 0, 0, 32'h81);
    check(!fd_tc_o, "R4 no tc without bit1", fd_tc_o, 0);
    expect_rd(AUX1, 0, 0, 32'h81, "R4 aux1 other bits");
  endtask

  task automatic t_power();
    wr(CFG, 0, 0, 32'h08);
    @(negedge clk); pwr_fail = 1'b1;
    @(negedge clk);
    check(irq_o, "R8 irq after power fail", irq_o, 1);
    expect_rd(AUX2, 0, 0, 32'h20, "R5 flag set when enabled");
    wr(CFG, 0, 0, 32'h00);
    check(!irq_o, "R8 irq drops with enable", irq_o, 0);
    expect_rd(AUX2, 0, 0, 32'h20, "R5 flag held on cfg write");
    wr(CFG, 0, 0, 32'h08);
    check(irq_o, "R8 irq back with enable", irq_o, 1);
    wr(AUX2, 0, 0, 32'hFC);
    expect_rd(AUX2, 0, 0, 32'h20, "R6 masked bits dropped, flag kept");
    check(!shutdown_o, "R7 no shutdown without bit0", shutdown_o, 0);
    wr(AUX2, 0, 0, 32'h02);
    check(!irq_o, "R6 clear drops irq", irq_o, 0);
    expect_rd(AUX2, 0, 0, 32'h00, "R6 clear bit wipes flag");
    @(negedge clk); pwr_fail = 1'b0;
    wr(CFG, 0, 0, 32'h00);
    @(negedge clk); pwr_fail = 1'b1;
    @(negedge clk);
    expect_rd(AUX2, 0, 0, 32'h00, "R5 flag not set when disabled");
    check(!irq_o, "R8 irq low when disabled", irq_o, 0);
    wr(CFG, 0, 0, 32'h08);
    @(negedge clk); pwr_fail = 1'b0;
    @(negedge clk); pwr_fail = 1'b1;
    @(negedge clk);
    expect_rd(AUX2, 0, 0, 32'h20, "R5 flag set again");
    @(negedge clk); pwr_fail = 1'b0;
    @(negedge clk);
    expect_rd(AUX2, 0, 0, 32'h00, "R5 flag cleared on deassert");
    wr(AUX2, 0, 0, 32'h01);
    check(shutdown_o, "R7 shutdown pulse", shutdown_o, 1);
    @(negedge clk);
    check(!shutdown_o, "R7 shutdown one cycle", shutdown_o, 0);
    expect_rd(AUX2, 0, 0, 32'h01, "R6 power-off bit stored");
    wr(AUX2, 0, 0, 32'h03);
    check(shutdown_o, "R7 shutdown with clear", shutdown_o, 1);
    expect_rd(AUX2, 0, 0, 32'h01, "R6 clear not stored");
  endtask

  task automatic t_sysctl();
    wr(SYS, 0, 2, 32'hFFFF_FFFE);
    check(!sys_reset_o, "R9 no request without bit0", sys_reset_o, 0);
    wr(SYS, 0, 2, 32'h1);
    check(sys_reset_o, "R9 reset request pulse", sys_reset_o, 1);
    @(negedge clk);
    check(!sys_reset_o, "R9 request one cycle", sys_reset_o, 0);
    expect_rd(SYS, 0, 2, 32'h02, "R9 status byte");
    expect_rd(SYS, 1, 2, 32'h0, "R3 sysctl offset read zero");
  endtask

  task automatic t_retain();
    wr(DIAG, 0, 0, 32'h77);
    wr(LED, 0, 1, 32'h1234);
    wr(MDM, 0, 0, 32'h44);
    wr(CFG, 0, 0, 32'h08);
    do_reset();
    expect_rd(DIAG, 0, 0, 32'h77, "R1 diag kept");
    expect_rd(LED, 0, 1, 32'h1234, "R1 led kept");
    expect_rd(SYS, 0, 2, 32'h02, "R1 status kept");
    expect_rd(MDM, 0, 0, 32'h0, "R1 modem cleared");
    expect_rd(CFG, 0, 0, 32'h0, "R1 cfg cleared");
    expect_rd(AUX2, 0, 0, 32'h0, "R1 aux2 cleared");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    t_reset_state();
    t_plain_rw();
    t_qualify();
    t_aux1();
    t_power();
    t_sysctl();
    t_retain();
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule